// File: doc/BRIEF.md
# Manchester II Serial Word Encoder

This block turns a serial stream of 16 data bits into one framed Manchester II word and drives it onto two active-low bipolar line outputs. A word is 20 bit times long. It opens with a 3-bit-time sync whose polarity marks the word as a command word or a data word. The 16 data bits follow, each split into two opposite half-bits. An odd parity bit closes the word. The whole block runs on one system clock. A single-cycle enable pulse `tick2x` arrives at twice the bit rate. Each half-bit of the line lasts one tick interval.

The block makes a bit-rate shift strobe, `shift_o`, which toggles on every tick. It also raises a data request, `req_o`, for exactly 16 strobe periods. While the request is high, an external source places one data bit on `sdata_i` after each falling strobe edge. The block samples that bit at the next rising strobe edge. The bit sampled first is the bit sent first. If `enable_i` is still high when a word reaches its last bit, the next word follows with no gap. A low `inhibit_n_i` forces both line outputs inactive and does not stop the sequencing. `mrst` aborts any word in progress.

The sequencer is a state machine with five states:
- ST_IDLE: no word is active.
- ST_ARMED: enable was seen at a falling strobe edge, and the first rising edge has not yet come.
- ST_SYNC, ST_DATA, ST_PARITY: the three regions of a word.

The transitions are:
- idle→armed: enable is high at a falling strobe edge.
- armed→sync: the next rising strobe edge. The sync type is latched here.
- sync→data and data→parity: the half-bit slot counter crosses a region boundary.
- parity→sync (chained word): the word ends, and enable was high at its last falling edge.
- parity→idle: the word ends, and enable was low at that edge.

Top module: `manch_word_enc`

## Requirements
- R1: `shift_o` is 0 after reset and toggles on every cycle in which `tick2x` is high, and only then. Its rising edge marks the start of a bit time, and its falling edge marks the middle of a bit time.
- R2: A word starts only when `enable_i` is high at a falling strobe edge. The first sync half-bit appears at the next rising edge, and the word lasts exactly 40 half-bits (20 strobe periods).
- R3: The sync select is latched at the first rising strobe edge of the word. Select 1 (command) gives 3 positive half-bits and then 3 negative half-bits. Select 0 (data) gives the mirror image.
- R4: `req_o` rises at the falling strobe edge that ends half-bit 4 of the word, and it stays high for exactly 16 strobe periods (32 half-bits). A data bit is sampled at each of the 16 rising edges inside that window, and the bits go out in the order they were sampled.
- R5: A data 1 is sent as a positive half-bit followed by a negative half-bit, and a data 0 as negative followed by positive. Positive drives `one_n_o` low, and negative drives `zero_n_o` low. The two outputs are never low together.
- R6: The parity bit is coded like a data bit. Its value makes the number of ones across the 16 data bits plus parity odd.
- R7: If `enable_i` is high at the falling strobe edge inside the last bit of a word, the next word's sync begins on the half-bit that follows that bit.
- R8: While `inhibit_n_i` is 0, both line outputs are 1. The request timing and the word sequence carry on unchanged, so a word that starts while inhibit is active is still sent in full.
- R9: `mrst` aborts a word in progress. After reset, both outputs are 1, `req_o` is 0 and `shift_o` is 0, and the block waits for a new enable.
- R10: Outside a word, and while the block is armed, both line outputs are 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| mrst | input | 1 | Master reset, active high, synchronous |
| tick2x | input | 1 | One-cycle enable pulse at twice the bit rate |
| enable_i | input | 1 | Requests a word; holding it high chains words |
| cmd_sel_i | input | 1 | Sync type: 1 gives a command sync, 0 a data sync |
| inhibit_n_i | input | 1 | Active low; forces both line outputs inactive |
| sdata_i | input | 1 | Serial data bit, sampled at a rising strobe edge |
| shift_o | output | 1 | Bit-rate shift strobe |
| req_o | output | 1 | Data request window |
| one_n_o | output | 1 | Active-low positive line drive |
| zero_n_o | output | 1 | Active-low negative line drive |

## Verification
The hardest case to reach is the change from one word to the next without a gap. Enable has to be high at exactly one falling edge, in the last bit of the running word. The sync select for the following word has to be presented long before that word's first edge. The bench reaches this case by driving enable, select and data from inside its tick loop. It lowers enable, or presents the next select, at the half-bit where the current word's request rises. The line is then decoded at half-bit resolution against positions computed from the word's start.

A second hard case is inhibit. It is held low for all of the first word of a chained pair and released at the boundary. The first word must leave the line idle while its request window still lasts 32 half-bits, and the second word must come out intact.

// File: rtl/mwe_pkg.sv
package mwe_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ARMED,
        ST_SYNC,
        ST_DATA,
        ST_PARITY
    } seq_state_t;

    typedef enum logic [1:0] {
        LV_IDLE,
        LV_POS,
        LV_NEG
    } line_lvl_t;

endpackage

// File: rtl/mwe_timebase.sv
module mwe_timebase (
    input  logic clk,
    input  logic rst,
    input  logic tick_i,
    output logic rise_o,
    output logic fall_o,
    output logic shift_o
);
    logic phase;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase <= 1'b0;
        end else if (tick_i) begin
            phase <= ~phase;
        end
    end

    assign rise_o  = tick_i & ~phase;
    assign fall_o  = tick_i & phase;
    assign shift_o = phase;
endmodule

// File: rtl/mwe_seq.sv
module mwe_seq
    import mwe_pkg::*;
#(
    parameter int DATA_BITS = 16,
    parameter int SYNC_BITS = 3,
    parameter int SW        = 6
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          rise_i,
    input  logic          fall_i,
    input  logic          enable_i,
    input  logic          cmd_sel_i,
    output logic          enter_o,
    output logic          start_o,
    output logic          stop_o,
    output logic [SW-1:0] slot_n_o,
    output logic          cmd_o,
    output logic          req_o
);
    localparam int SYNC_SLOTS = 2 * SYNC_BITS;
    localparam int PAR_SLOT   = SYNC_SLOTS + 2 * DATA_BITS;
    localparam int WORD_SLOTS = PAR_SLOT + 2;
    localparam logic [SW-1:0] S_DATA   = SW'(SYNC_SLOTS);
    localparam logic [SW-1:0] S_PAR    = SW'(PAR_SLOT);
    localparam logic [SW-1:0] S_LAST   = SW'(WORD_SLOTS - 1);
    localparam logic [SW-1:0] S_REQ_ON = SW'(SYNC_SLOTS - 1);
    localparam logic [SW-1:0] S_REQOFF = SW'(PAR_SLOT - 1);

    seq_state_t    st, st_n;
    logic [SW-1:0] slot, slot_d, nxt;
    logic          again, again_d;
    logic          enter, start, stop;
    logic          cmd_q;

    function automatic seq_state_t region(input logic [SW-1:0] s);
        if (s < S_DATA) begin
            return ST_SYNC;
        end else if (s < S_PAR) begin
            return ST_DATA;
        end
        return ST_PARITY;
    endfunction

    always_comb begin
        st_n    = st;
        slot_d  = slot;
        again_d = again;
        enter   = 1'b0;
        start   = 1'b0;
        stop    = 1'b0;
        nxt     = slot + 1'b1;
        unique case (st)
            ST_IDLE: begin
                if (fall_i && enable_i) begin
                    st_n = ST_ARMED;
                end
            end
            ST_ARMED: begin
                if (rise_i) begin
                    st_n    = ST_SYNC;
                    slot_d  = '0;
                    enter   = 1'b1;
                    start   = 1'b1;
                    again_d = 1'b0;
                end
            end
            ST_SYNC, ST_DATA, ST_PARITY: begin
                if (rise_i || fall_i) begin
                    if (slot == S_LAST) begin
                        slot_d = '0;
                        if (again) begin
                            st_n    = ST_SYNC;
                            enter   = 1'b1;
                            start   = 1'b1;
                            again_d = 1'b0;
                        end else begin
                            st_n = ST_IDLE;
                            stop = 1'b1;
                        end
                    end else begin
                        slot_d = nxt;
                        enter  = 1'b1;
                        st_n   = region(nxt);
                        if (fall_i && (nxt == S_LAST) && enable_i) begin
                            again_d = 1'b1;
                        end
                    end
                end
            end
            default: st_n = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (rst) begin
            st    <= ST_IDLE;
            slot  <= '0;
            again <= 1'b0;
        end else begin
            st    <= st_n;
            slot  <= slot_d;
            again <= again_d;
        end
    end

    // registered outputs
    always_ff @(posedge clk) begin
        if (rst) begin
            cmd_q <= 1'b0;
            req_o <= 1'b0;
        end else begin
            if (start) begin
                cmd_q <= cmd_sel_i;
            end
            if (enter && (slot_d == S_REQ_ON)) begin
                req_o <= 1'b1;
            end else if (enter && (slot_d == S_REQOFF)) begin
                req_o <= 1'b0;
            end
        end
    end

    assign enter_o  = enter;
    assign start_o  = start;
    assign stop_o   = stop;
    assign slot_n_o = slot_d;
    assign cmd_o    = start ? cmd_sel_i : cmd_q;
endmodule

// File: rtl/mwe_shaper.sv
module mwe_shaper
    import mwe_pkg::*;
#(
    parameter int DATA_BITS = 16,
    parameter int SYNC_BITS = 3,
    parameter int SW        = 6
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          enter_i,
    input  logic          stop_i,
    input  logic [SW-1:0] slot_n_i,
    input  logic          cmd_i,
    input  logic          sdata_i,
    output line_lvl_t     line_o
);
    localparam logic [SW-1:0] S_HALF = SW'(SYNC_BITS);
    localparam logic [SW-1:0] S_DATA = SW'(2 * SYNC_BITS);
    localparam logic [SW-1:0] S_PAR  = SW'(2 * SYNC_BITS + 2 * DATA_BITS);

    line_lvl_t line, line_d;
    logic      bitq, bit_d;
    logic      par, par_d;
    logic      lead;
    logic      pbit;

    always_comb begin
        line_d = line;
        bit_d  = bitq;
        par_d  = par;
        lead   = slot_n_i < S_HALF;
        pbit   = ~par;
        if (stop_i) begin
            line_d = LV_IDLE;
        end else if (enter_i) begin
            if (slot_n_i < S_DATA) begin
                line_d = (cmd_i == lead) ? LV_POS : LV_NEG;
                par_d  = 1'b0;
            end else if (slot_n_i < S_PAR) begin
                if (!slot_n_i[0]) begin
                    bit_d  = sdata_i;
                    par_d  = par ^ sdata_i;
                    line_d = sdata_i ? LV_POS : LV_NEG;
                end else begin
                    line_d = bitq ? LV_NEG : LV_POS;
                end
            end else begin
                if (!slot_n_i[0]) begin
                    line_d = pbit ? LV_POS : LV_NEG;
                end else begin
                    line_d = pbit ? LV_NEG : LV_POS;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            line <= LV_IDLE;
            bitq <= 1'b0;
            par  <= 1'b0;
        end else begin
            line <= line_d;
            bitq <= bit_d;
            par  <= par_d;
        end
    end

    assign line_o = line;
endmodule

// File: rtl/mwe_linegate.sv
module mwe_linegate
    import mwe_pkg::*;
(
    input  line_lvl_t line_i,
    input  logic      inhibit_n_i,
    output logic      one_n_o,
    output logic      zero_n_o
);
    assign one_n_o  = ~(inhibit_n_i & (line_i == LV_POS));
    assign zero_n_o = ~(inhibit_n_i & (line_i == LV_NEG));
endmodule

// File: rtl/manch_word_enc.sv
module manch_word_enc
    import mwe_pkg::*;
#(
    parameter int DATA_BITS = 16,
    parameter int SYNC_BITS = 3
) (
    input  logic clk,
    input  logic mrst,
    input  logic tick2x,
    input  logic enable_i,
    input  logic cmd_sel_i,
    input  logic inhibit_n_i,
    input  logic sdata_i,
    output logic shift_o,
    output logic req_o,
    output logic one_n_o,
    output logic zero_n_o
);
    localparam int WORD_SLOTS = 2 * SYNC_BITS + 2 * DATA_BITS + 2;
    localparam int SW         = $clog2(WORD_SLOTS);

    logic          rise, fall;
    logic          enter, start, stop, cmd;
    logic [SW-1:0] slot_n;
    line_lvl_t     line;

    mwe_timebase u_tb (
        .clk     (clk),
        .rst     (mrst),
        .tick_i  (tick2x),
        .rise_o  (rise),
        .fall_o  (fall),
        .shift_o (shift_o)
    );

    mwe_seq #(.DATA_BITS(DATA_BITS), .SYNC_BITS(SYNC_BITS), .SW(SW)) u_seq (
        .clk       (clk),
        .rst       (mrst),
        .rise_i    (rise),
        .fall_i    (fall),
        .enable_i  (enable_i),
        .cmd_sel_i (cmd_sel_i),
        .enter_o   (enter),
        .start_o   (start),
        .stop_o    (stop),
        .slot_n_o  (slot_n),
        .cmd_o     (cmd),
        .req_o     (req_o)
    );

    mwe_shaper #(.DATA_BITS(DATA_BITS), .SYNC_BITS(SYNC_BITS), .SW(SW)) u_shp (
        .clk      (clk),
        .rst      (mrst),
        .enter_i  (enter),
        .stop_i   (stop),
        .slot_n_i (slot_n),
        .cmd_i    (cmd),
        .sdata_i  (sdata_i),
        .line_o   (line)
    );

    mwe_linegate u_gate (
        .line_i      (line),
        .inhibit_n_i (inhibit_n_i),
        .one_n_o     (one_n_o),
        .zero_n_o    (zero_n_o)
    );

    // start is consumed inside the sequencer and shaper paths only
    logic unused_start;
    assign unused_start = start;
endmodule

// File: rtl/mwe_chk.sv
module mwe_chk #(
    parameter int DATA_BITS = 16
) (
    input logic clk,
    input logic mrst,
    input logic tick2x,
    input logic inhibit_n_i,
    input logic shift_o,
    input logic req_o,
    input logic one_n_o,
    input logic zero_n_o
);
    localparam int CW = $clog2(DATA_BITS + 2);

    logic [CW-1:0] rises;

    always_ff @(posedge clk) begin
        if (mrst || !req_o) begin
            rises <= '0;
        end else if (tick2x && !shift_o) begin
            rises <= rises + 1'b1;
        end
    end

    AST_SHIFT_TOGGLE: assert property (@(posedge clk) disable iff (mrst)
        tick2x |=> (shift_o != $past(shift_o)));                          // R1
    AST_SHIFT_HOLD: assert property (@(posedge clk) disable iff (mrst)
        !tick2x |=> $stable(shift_o));                                    // R1
    AST_REQ_ON_FALL: assert property (@(posedge clk) disable iff (mrst)
        $rose(req_o) |-> $fell(shift_o));                                 // R4
    AST_REQ_WINDOW: assert property (@(posedge clk) disable iff (mrst)
        $fell(req_o) |-> (rises == CW'(DATA_BITS)));                      // R4
    AST_NEVER_BOTH: assert property (@(posedge clk) disable iff (mrst)
        !(!one_n_o && !zero_n_o));                                        // R5
    AST_INHIBIT_IDLE: assert property (@(posedge clk) disable iff (mrst)
        !inhibit_n_i |-> (one_n_o && zero_n_o));                          // R8
    AST_RESET_QUIET: assert property (@(posedge clk) disable iff (mrst)
        $past(mrst) |-> (one_n_o && zero_n_o && !req_o && !shift_o));     // R9
endmodule

bind manch_word_enc mwe_chk #(.DATA_BITS(DATA_BITS)) u_chk (
    .clk         (clk),
    .mrst        (mrst),
    .tick2x      (tick2x),
    .inhibit_n_i (inhibit_n_i),
    .shift_o     (shift_o),
    .req_o       (req_o),
    .one_n_o     (one_n_o),
    .zero_n_o    (zero_n_o)
);

// File: tb/manch_word_enc_test.sv
module manch_word_enc_test;
    logic clk = 1'b0;
    logic mrst = 1'b1, tick2x = 1'b0, enable_i = 1'b0, cmd_sel_i = 1'b0;
    logic inhibit_n_i = 1'b1, sdata_i = 1'b0;
    logic shift_o, req_o, one_n_o, zero_n_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    manch_word_enc uut (
        .clk(clk), .mrst(mrst), .tick2x(tick2x), .enable_i(enable_i),
        .cmd_sel_i(cmd_sel_i), .inhibit_n_i(inhibit_n_i), .sdata_i(sdata_i),
        .shift_o(shift_o), .req_o(req_o), .one_n_o(one_n_o), .zero_n_o(zero_n_o)
    );

    // {sync select, data}
    localparam logic [16:0] VEC [0:7] = '{
        17'h1_A5C3, 17'h0_3C96, 17'h1_0000, 17'h0_FFFF,
        17'h1_8001, 17'h0_5555, 17'h1_7E1F, 17'h0_C2B4
    };

    logic [1:0]  lg_lvl  [0:511];
    logic        lg_strb [0:511];
    logic        lg_req  [0:511];
    logic        cur_sel [0:7];
    logic [15:0] cur_dat [0:7];

    localparam logic [1:0] L_POS  = 2'b01;
    localparam logic [1:0] L_NEG  = 2'b10;
    localparam logic [1:0] L_IDLE = 2'b11;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", tag, act, exp);
        end
    endtask

    function automatic logic [1:0] exp_lvl(input int j, input logic s, input logic [15:0] d);
        bit pos;
        bit b;
        if (j < 6) begin
            pos = (s == (j < 3));
        end else if (j < 38) begin
            b   = d[15 - (j - 6) / 2];
            pos = (j % 2 == 0) ? b : !b;
        end else begin
            b   = ~^d;
            pos = (j % 2 == 0) ? b : !b;
        end
        return pos ? L_POS : L_NEG;
    endfunction

    // mode 0: plain, 1: inhibit during word 0, 2: reset abort
    task automatic run(input int n, input int mode, output int total);
        int cnt, nlog, reqs, bi, wp;
        bit prev_tick, prev_req;
        total = (mode == 2) ? 60 : 2 + 40 * n + 12;
        mrst = 1'b1; enable_i = 1'b0; tick2x = 1'b0; sdata_i = 1'b0;
        inhibit_n_i = (mode == 1) ? 1'b0 : 1'b1;
        repeat (4) @(negedge clk);
        mrst = 1'b0;
        // R9: quiet state after reset
        chk(one_n_o && zero_n_o && !req_o && !shift_o, "R9 reset state",
            {one_n_o, zero_n_o, req_o, shift_o}, 12);
        cnt = 0; nlog = 0; reqs = 0; bi = 0; wp = -1;
        prev_tick = 1'b0; prev_req = 1'b0;
        cmd_sel_i = cur_sel[0];
        enable_i  = 1'b1;
        while (nlog < total) begin
            @(negedge clk);
            if (prev_tick) begin
                lg_lvl[nlog]  = {one_n_o, zero_n_o};
                lg_strb[nlog] = shift_o;
                lg_req[nlog]  = req_o;
                if (req_o && !prev_req) begin
                    reqs++; wp++; bi = 0;
                    if (reqs >= n) enable_i = 1'b0;
                    else cmd_sel_i = cur_sel[reqs];
                end
                prev_req = req_o;
                if (req_o && !shift_o && bi < 16 && wp >= 0) begin
                    sdata_i = cur_dat[wp][15 - bi];
                    bi++;
                end
                nlog++;
                if (mode == 1 && nlog == 42) inhibit_n_i = 1'b1;
                if (mode == 2 && nlog == 20) begin
                    mrst = 1'b1; enable_i = 1'b0;
                end
                if (mode == 2 && nlog == 23) mrst = 1'b0;
            end
            tick2x = (cnt == 3);
            prev_tick = tick2x;
            cnt = (cnt + 1) % 4;
        end
        tick2x = 1'b0;
    endtask

    task automatic verify(input int n, input int mode, input int total);
        int bad, base, rq;
        logic [15:0] v;
        bad = 0;
        for (int i = 1; i < total; i++) if (lg_strb[i] == lg_strb[i-1]) bad++;
        chk(lg_strb[0] == 1'b1 && bad == 0, "R1 strobe toggles per tick", bad, 0);
        chk(lg_lvl[0] == L_IDLE && lg_lvl[1] == L_IDLE, "R10 idle while armed",
            lg_lvl[1], L_IDLE);
        for (int k = 0; k < n; k++) begin
            base = 2 + 40 * k;
            rq = 0;
            for (int j = 0; j < 40; j++) if (lg_req[base + j]) rq++;
            chk(rq == 32 && !lg_req[base + 4] && lg_req[base + 5], "R4 request window",
                rq, 32);
            if (mode == 1 && k == 0) begin
                bad = 0;
                for (int j = 0; j < 40; j++) if (lg_lvl[base + j] != L_IDLE) bad++;
                chk(bad == 0, "R8 inhibit holds outputs high", bad, 0);
            end else begin
                bad = 0;
                for (int j = 0; j < 6; j++)
                    if (lg_lvl[base + j] != exp_lvl(j, cur_sel[k], cur_dat[k])) bad++;
                chk(bad == 0, "R3 sync polarity", bad, 0);
                if (k == 0) chk(bad == 0, "R2 first half-bit after arming", bad, 0);
                if (k > 0) chk(lg_lvl[base] == exp_lvl(0, cur_sel[k], cur_dat[k]),
                               "R7 gapless next sync", lg_lvl[base],
                               exp_lvl(0, cur_sel[k], cur_dat[k]));
                v = '0;
                for (int b = 0; b < 16; b++) v = {v[14:0], lg_lvl[base + 6 + 2*b] == L_POS};
                chk(v == cur_dat[k], "R4 data order", v, cur_dat[k]);
                bad = 0;
                for (int j = 6; j < 38; j++)
                    if (lg_lvl[base + j] != exp_lvl(j, cur_sel[k], cur_dat[k])) bad++;
                chk(bad == 0, "R5 Manchester halves", bad, 0);
                bad = 0;
                for (int j = 38; j < 40; j++)
                    if (lg_lvl[base + j] != exp_lvl(j, cur_sel[k], cur_dat[k])) bad++;
                chk(bad == 0, "R6 odd parity bit", bad, 0);
            end
        end
        bad = 0;
        for (int i = 2 + 40 * n; i < total; i++)
            if (lg_lvl[i] != L_IDLE || lg_req[i]) bad++;
        chk(bad == 0, "R2 word ends after 20 periods (R10 idle)", bad, 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        int total, bad;
        // table walk: single words
        for (int i = 0; i < 8; i++) begin
            cur_sel[0] = VEC[i][16];
            cur_dat[0] = VEC[i][15:0];
            run(1, 0, total);
            verify(1, 0, total);
        end
        // back-to-back words, alternating sync types (R7)
        for (int i = 0; i < 4; i++) begin
            cur_sel[i] = VEC[i][16];
            cur_dat[i] = VEC[i][15:0];
        end
        run(4, 0, total);
        verify(4, 0, total);
        // inhibit over first word of a pair (R8)
        cur_sel[0] = VEC[5][16]; cur_dat[0] = VEC[5][15:0];
        cur_sel[1] = VEC[6][16]; cur_dat[1] = VEC[6][15:0];
        run(2, 1, total);
        verify(2, 1, total);
        // reset abort mid-word (R9)
        cur_sel[0] = VEC[7][16]; cur_dat[0] = VEC[7][15:0];
        run(1, 2, total);
        chk(lg_lvl[19] != L_IDLE, "R9 word active before abort", lg_lvl[19], 0);
        bad = 0;
        for (int i = 20; i < 60; i++) if (lg_lvl[i] != L_IDLE || lg_req[i]) bad++;
        for (int i = 20; i < 23; i++) if (lg_strb[i]) bad++;
        chk(bad == 0, "R9 abort leaves block idle", bad, 0);
        // ready for a new word after the abort
        run(1, 0, total);
        verify(1, 0, total);
        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule